// File: doc/BRIEF.md
# Capture-Restart Interval Timer

A 16-bit up-counter that measures the spacing of edges on one input pin. The system clock drives the counter through a prescaler that divides by a power of two. When the chosen edge arrives on the pin, the running count is stored in a capture register. The counter then starts again from 0001h and an interrupt pulse is raised. If no edge arrives, the counter runs until it matches a programmed reload value. It then starts again from 0001h and also interrupts.

A status flag tells software whether the latest restart came from a capture or from a reload. A two-bit field chooses the interrupt sources: both, captures only, or reloads only. Software stops the timer, writes the start count and the reload value, then sets the enable bit. Registers are reached through a simple byte-wide write/read port.

Top module: `cr_timer`

## Requirements
- R1: After reset, the register port reads: control 00h, status 00h, count 0001h, reload FFFFh, capture 0000h. `irq_o` is low.
- R2: Control bits [4:2] set the prescale N, and the counter advances once every 2^N clocks. The prescaler starts again from zero when the timer is enabled and on every restart. With start 0001h and reload R, the first reload interrupt arrives R*2^N cycles after the enabling write takes effect.
- R3: On a prescaled tick where the count equals the reload value, the count becomes 0001h on the next cycle, the status flag (status bit 0) is cleared and an interrupt pulse is raised.
- R4: On the selected pin edge while enabled, the capture register takes the count held before the edge was acted on. The count becomes 0001h, status bit 0 is set and an interrupt pulse is raised. All of this takes effect on the third rising clock edge after the pin changes (two synchroniser stages plus one action edge).
- R5: Control bit 1 selects the capture edge: 0 for rising, 1 for falling. An edge of the other direction has no effect.
- R6: Control bits [6:5] select the interrupt sources: 00 or 11 for both, 01 for capture only, 10 for reload only. A masked event still restarts the count and still updates the status flag.
- R7: If a capture and a reload match fall on the same clock edge, the capture takes precedence. The capture register is written, the status flag is set and only one interrupt pulse is raised.
- R8: `irq_o` is high for exactly one clock per event. The status flag keeps its value until the next capture or reload.
- R9: While control bit 0 (enable) is clear, the count holds and pin edges are ignored. Writes to the count bytes take effect only while the timer is disabled.
- R10: The register map is: 0 control, 1 status, 2/3 count low/high, 4/5 reload low/high, 6/7 capture low/high. Control and reload read back as written, with control bit 7 reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from `addr_i` |
| tin_i | input | 1 | Timer input pin, asynchronous |
| irq_o | output | 1 | Interrupt pulse, one clock per enabled event |

## Verification
The control write that sets the enable bit takes effect on the clock edge after the strobe, and every expected interrupt time is counted from that edge. A reload interrupt falls R*2^N edges later. A capture interrupt falls on the third edge after the pin is driven, and the value captured is the count after the second of those edges. The driver pushes the exact expected cycle of each interrupt into a queue. The monitor reports any pulse in another cycle and any queued pulse that never arrives. Register reads happen one nanosecond after a falling clock edge, so counts read while the timer runs are computed from the cycle index at that instant.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int PSC_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd6;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd7;

  localparam logic [CNT_W-1:0] CNT_RESTART = CNT_W'(1);
  localparam logic [CNT_W-1:0] RLD_RESET   = '1;

  typedef enum logic [1:0] {
    IRQ_ALL   = 2'b00,
    IRQ_CAP   = 2'b01,
    IRQ_RLD   = 2'b10,
    IRQ_ALL_B = 2'b11
  } irq_sel_e;

  typedef struct packed {
    logic             spare;
    irq_sel_e         irq_sel;
    logic [PSC_W-1:0] psc;
    logic             fall;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/cr_prescaler.sv
module cr_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb mask = ~({DIV_W{1'b1}} << sel_i);

  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || clr_i)   div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  AST_PSC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && sel_i != '0) |=> (!tick_o || sel_i == '0)); // R2
endmodule

// File: rtl/cr_edge_det.sv
module cr_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level;

  assign level = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level;
  end

  assign evt_o = fall_i ? (prev_q && !level) : (!prev_q && level);

  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o); // R4
endmodule

// File: rtl/cr_core.sv
module cr_core
  import cr_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              cap_evt_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  irq_sel_e          irq_sel_i,
  input  logic              cnt_we_lo_i,
  input  logic              cnt_we_hi_i,
  input  logic [DATA_W-1:0] wbyte_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  capture_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              restart_o
);
  logic [CNT_W-1:0] count_q, capture_q;
  logic             flag_q, irq_q;
  logic             cap_hit, rld_match, rld_hit;

  assign cap_hit   = en_i && cap_evt_i;
  assign rld_match = en_i && tick_i && (count_q == reload_i);
  assign rld_hit   = rld_match && !cap_hit;
  assign restart_o = cap_hit || rld_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= CNT_RESTART;
      capture_q <= '0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cap_hit) begin
        capture_q <= count_q;
        count_q   <= CNT_RESTART;
        flag_q    <= 1'b1;
        irq_q     <= (irq_sel_i != IRQ_RLD);
      end else if (rld_hit) begin
        count_q <= CNT_RESTART;
        flag_q  <= 1'b0;
        irq_q   <= (irq_sel_i != IRQ_CAP);
      end else if (en_i) begin
        if (tick_i) count_q <= count_q + 1'b1;
      end else begin
        if (cnt_we_lo_i) count_q[DATA_W-1:0]     <= wbyte_i;
        if (cnt_we_hi_i) count_q[CNT_W-1:DATA_W] <= wbyte_i;
      end
    end
  end

  assign count_o   = count_q;
  assign capture_o = capture_q;
  assign flag_o    = flag_q;
  assign irq_o     = irq_q;

  AST_RESTART_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> count_q == CNT_RESTART); // R3
  AST_CAP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |=> (capture_q == $past(count_q)) && flag_q); // R4
  AST_CAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_hit && rld_match) |=> flag_q); // R7
  AST_MASK_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && $past(irq_sel_i) == IRQ_CAP) |-> flag_q); // R6
  AST_MASK_RLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && $past(irq_sel_i) == IRQ_RLD) |-> !flag_q); // R6
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_we_lo_i && !cnt_we_hi_i) |=> $stable(count_q)); // R9
endmodule

// File: rtl/cr_timer.sv
module cr_timer
  import cr_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tin_i,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] count, capture;
  logic             flag, tick, cap_evt, restart;
  logic             cnt_we_lo, cnt_we_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rld_q  <= RLD_RESET;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL:   ctrl_q <= ctrl_t'({1'b0, wdata_i[DATA_W-2:0]});
        A_RLD_LO: rld_q[DATA_W-1:0]     <= wdata_i;
        A_RLD_HI: rld_q[CNT_W-1:DATA_W] <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cnt_we_lo = we_i && (addr_i == A_CNT_LO);
  assign cnt_we_hi = we_i && (addr_i == A_CNT_HI);

  cr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.en),
    .clr_i  (restart),
    .sel_i  (ctrl_q.psc),
    .tick_o (tick)
  );

  cr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (tin_i),
    .fall_i (ctrl_q.fall),
    .evt_o  (cap_evt)
  );

  cr_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl_q.en),
    .tick_i      (tick),
    .cap_evt_i   (cap_evt),
    .reload_i    (rld_q),
    .irq_sel_i   (ctrl_q.irq_sel),
    .cnt_we_lo_i (cnt_we_lo),
    .cnt_we_hi_i (cnt_we_hi),
    .wbyte_i     (wdata_i),
    .count_o     (count),
    .capture_o   (capture),
    .flag_o      (flag),
    .irq_o       (irq_o),
    .restart_o   (restart)
  );

  always_comb begin
    case (addr_i)
      A_CTRL:   rdata_o = ctrl_q;
      A_STAT:   rdata_o = {{(DATA_W-1){1'b0}}, flag};
      A_CNT_LO: rdata_o = count[DATA_W-1:0];
      A_CNT_HI: rdata_o = count[CNT_W-1:DATA_W];
      A_RLD_LO: rdata_o = rld_q[DATA_W-1:0];
      A_RLD_HI: rdata_o = rld_q[CNT_W-1:DATA_W];
      A_CAP_LO: rdata_o = capture[DATA_W-1:0];
      default:  rdata_o = capture[CNT_W-1:DATA_W];
    endcase
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctrl_q.en)); // R9
  AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.spare); // R10
endmodule

// File: tb/tb_cr_timer.sv
`timescale 1ns/100ps
module tb_cr_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tin = 1'b0;
  logic       irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_eff = 0;
  bit done = 1'b0;
  int    exp_cyc[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cr_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tin_i(tin), .irq_o(irq)
  );

  task automatic push_irq(input int c, input string tag);
    exp_cyc.push_back(c);
    exp_tag.push_back(tag);
  endtask

  // monitor: pops expected interrupt cycles
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        checks++; failures++;
        $display("FAIL %s: irq missing, got none expected cycle %0d", exp_tag[0], exp_cyc[0]);
        void'(exp_cyc.pop_front()); void'(exp_tag.pop_front());
      end
      if (irq) begin
        checks++;
        if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
          void'(exp_cyc.pop_front()); void'(exp_tag.pop_front());
        end else begin
          failures++;
          $display("FAIL R8: irq at cycle %0d, expected %0d", cyc,
                   (exp_cyc.size() > 0) ? exp_cyc[0] : -1);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; last_eff = cyc + 1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== 8'(exp)) begin
      failures++;
      $display("FAIL %s: addr %0d got %02h expected %02h", tag, a, rdata, 8'(exp));
    end
    @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic setup(input int cnt, input int rld);
    wr(3'd2, 8'(cnt)); wr(3'd3, 8'(cnt >> 8));
    wr(3'd4, 8'(rld)); wr(3'd5, 8'(rld >> 8));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R8: watchdog, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e0, m, d, w, v;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    checks++;
    if (irq !== 1'b0) begin failures++; $display("FAIL R1: irq got %b expected 0", irq); end
    rd_chk(3'd0, 8'h00, "R1"); rd_chk(3'd1, 8'h00, "R1");
    rd_chk(3'd2, 8'h01, "R1"); rd_chk(3'd3, 8'h00, "R1");
    rd_chk(3'd4, 8'hFF, "R1"); rd_chk(3'd5, 8'hFF, "R1");
    rd_chk(3'd6, 8'h00, "R1"); rd_chk(3'd7, 8'h00, "R1");

    // R3 reload period, div 1
    setup(1, 5);
    wr(3'd0, 8'h01); e0 = last_eff;
    push_irq(e0 + 5, "R3"); push_irq(e0 + 10, "R3");
    wait_until(e0 + 11);
    wr(3'd0, 8'h00); d = last_eff;
    rd_chk(3'd1, 0, "R3");
    v = 1 + (d - (e0 + 10));
    rd_chk(3'd2, v, "R9");
    idle(3);
    rd_chk(3'd2, v, "R9");

    // R2 prescale divide by 4
    setup(1, 3);
    wr(3'd0, 8'h09); e0 = last_eff;
    push_irq(e0 + 12, "R2"); push_irq(e0 + 24, "R2");
    rd_chk(3'd0, 8'h09, "R10");
    rd_chk(3'd4, 8'h03, "R10");
    wait_until(e0 + 25);
    wr(3'd0, 8'h00);

    // R4 rising capture
    setup(1, 255);
    wr(3'd0, 8'h01); e0 = last_eff;
    m = e0 + 10;
    wait_until(m); tin = 1'b1;
    push_irq(m + 3, "R4");
    wait_until(m + 4);
    rd_chk(3'd6, 1 + (m + 2 - e0), "R4");
    rd_chk(3'd7, 0, "R4");
    rd_chk(3'd1, 1, "R4");
    wait_until(m + 6); tin = 1'b0;   // R5 falling edge ignored
    wait_until(m + 12);
    rd_chk(3'd2, 1 + (m + 12 - (m + 3)), "R5");
    wr(3'd0, 8'h00);

    // R5 falling capture
    setup(1, 255);
    wr(3'd0, 8'h03); e0 = last_eff;
    wait_until(e0 + 4); tin = 1'b1;
    m = e0 + 20;
    wait_until(m); tin = 1'b0;
    push_irq(m + 3, "R5");
    wait_until(m + 4);
    rd_chk(3'd6, 1 + (m + 2 - e0), "R5");
    rd_chk(3'd1, 1, "R5");
    wr(3'd0, 8'h00);

    // R6 capture-only
    setup(1, 5);
    wr(3'd0, 8'h21); e0 = last_eff;
    wait_until(e0 + 7);
    rd_chk(3'd1, 0, "R6");
    wait_until(e0 + 8); tin = 1'b1;
    push_irq(e0 + 11, "R6");
    wait_until(e0 + 12);
    rd_chk(3'd6, 1, "R6");
    rd_chk(3'd1, 1, "R6");
    wr(3'd0, 8'h00);

    // R6 reload-only
    setup(1, 5);
    tin = 1'b0; idle(4);
    wr(3'd0, 8'h41); e0 = last_eff;
    wait_until(e0 + 1); tin = 1'b1;
    push_irq(e0 + 9, "R6");
    wait_until(e0 + 6);
    rd_chk(3'd1, 1, "R6");
    rd_chk(3'd6, 4, "R6");
    wait_until(e0 + 10);
    rd_chk(3'd1, 0, "R6");
    wr(3'd0, 8'h00);

    // R7 simultaneous capture and reload
    tin = 1'b0; idle(4);
    setup(1, 6);
    wr(3'd0, 8'h01); e0 = last_eff;
    wait_until(e0 + 3); tin = 1'b1;
    push_irq(e0 + 6, "R7"); push_irq(e0 + 12, "R7");
    wait_until(e0 + 8);
    rd_chk(3'd1, 1, "R7");
    rd_chk(3'd6, 6, "R7");
    wait_until(e0 + 13);
    wr(3'd0, 8'h00);

    // R9 count writes ignored while enabled; edges ignored while disabled
    setup(1, 255);
    wr(3'd0, 8'h01); e0 = last_eff;
    wr(3'd2, 8'h80); w = cyc;
    rd_chk(3'd2, 1 + (w - e0), "R9");
    wr(3'd0, 8'h00); d = last_eff;
    v = 1 + (d - e0);
    rd_chk(3'd2, v, "R9");
    tin = 1'b0; idle(4);
    tin = 1'b1; idle(6);
    rd_chk(3'd2, v, "R9");
    rd_chk(3'd1, 0, "R9");
    rd_chk(3'd6, 6, "R9");

    idle(4);
    checks++;
    if (exp_cyc.size() != 0) begin
      failures++;
      $display("FAIL R8: pending irq got %0d expected 0", exp_cyc.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule